// File: doc/BRIEF.md
# Register-Mapped Debug UART

A serial port for console and debug traffic, controlled over a simple 32-bit register bus. Software programs a baud divisor, a parity style and a channel routing mode. It then enables the receiver and transmitter through write-only command bits. Characters are exchanged one at a time through a single receive holding register and a single transmit holding register. Each character on the line is one start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit.

Status flags report a waiting received byte, room for a transmit byte, a fully idle transmitter, and three sticky error conditions: overrun, framing and parity. Each flag can be routed to a level interrupt through a mask. The mask is set by writing ones to one register and cleared by writing ones to another. Three routing modes in addition to normal operation support bring-up and link testing: the line can be echoed back, looped inside the block, or looped at the pins with the processor side disconnected.

A bus access is a single cycle with `bus_sel` high. Read data appears on `bus_rdata` on the clock edge that follows and is held until the next read.

Top module: `dbg_uart`

## Requirements
- R1: Register offsets are: command 0x00, mode 0x04, mask set 0x08, mask clear 0x0C, mask 0x10, status 0x14, receive holding 0x18, transmit holding 0x1C, divisor 0x20. After reset, status, mask and `irq_o` read 0, `txd_o` is high, and mode and divisor read back what was written.
- R2: Command bits are: bit 2 receiver reset, bit 3 transmitter reset, bit 4 receiver enable, bit 5 receiver disable, bit 6 transmitter enable, bit 7 transmitter disable, bit 8 clear errors. When enable and disable of one side are written together, that side ends up disabled. A disabled receiver sets nothing, and a disabled transmitter shows TXRDY low.
- R3: A character is a low start bit, 8 data bits LSB first, an optional parity bit and a high stop bit. Each bit lasts 16 times the divisor value in clock cycles.
- R4: Mode bits 11:9 select parity: 0 even, 1 odd, 2 constant 0, 3 constant 1, 4 to 7 no parity bit. The transmitter sends the selected bit and the receiver checks it.
- R5: Status bit 0 (RXRDY) sets when a character completes and clears when the receive holding register is read. A low pulse shorter than half a bit is not taken as a start bit.
- R6: If a character completes while RXRDY is still set, status bit 5 (OVRE) sets and the receive holding register holds the newer byte.
- R7: Status bit 6 (FRAME) sets when the stop bit is sampled low, and status bit 7 (PARE) sets on a parity mismatch. OVRE, FRAME and PARE stay set, even across a holding register read, until command bit 8 is written.
- R8: Status bit 1 (TXRDY) is high when the transmitter is enabled and its holding register is empty. Status bit 9 (TXEMPTY) is high when, in addition, no character is being shifted out. A write to the transmit holding register while TXRDY is low is ignored.
- R9: Writing ones to the mask set register sets those mask bits, and writing ones to the mask clear register clears them. Only status bits 0, 1, 5, 6, 7 and 9 can be masked in. `irq_o` is high when any status bit is set together with its mask bit.
- R10: Mode bits 15:14 select routing: 0 normal, 1 echo, 2 local loopback, 3 remote loopback. In echo mode `rxd_i` is copied to `txd_o` and the receiver still receives it.
- R11: In local loopback the transmitter feeds the receiver inside the block, and `txd_o` stays high.
- R12: In remote loopback `rxd_i` is copied to `txd_o` and the receiver sees an idle line, so RXRDY does not set.
- R13: A transmitter reset stops the character in progress, returns `txd_o` to high and empties the holding register. A receiver reset drops the character in progress and clears RXRDY. Neither reset changes the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line, registered |
| irq_o | output | 1 | Level interrupt, registered |

## Verification
Register reads show their value one edge after the access. The bench therefore drives a read on one falling edge and takes `bus_rdata` on the next falling edge. `irq_o` follows a status or mask change by one more edge, and the bench samples it only after a full read has gone by. A received character sets RXRDY in the middle of its stop bit, with the line passing through two synchroniser stages and a one-tick-per-divisor start search. The bench reads status only after it has driven the whole stop bit, or it polls for RXRDY in loopback. The transmit pin is decoded by finding the falling start edge and sampling half a bit period later and then once per bit period. In echo and remote loopback the pin lags the input by three cycles, so those checks sample at mid-bit, far from any edge.

// File: rtl/dbg_uart_pkg.sv
package dbg_uart_pkg;

  localparam logic [7:0] OFF_CMD  = 8'h00;
  localparam logic [7:0] OFF_MODE = 8'h04;
  localparam logic [7:0] OFF_MSET = 8'h08;
  localparam logic [7:0] OFF_MCLR = 8'h0C;
  localparam logic [7:0] OFF_MASK = 8'h10;
  localparam logic [7:0] OFF_STAT = 8'h14;
  localparam logic [7:0] OFF_RHR  = 8'h18;
  localparam logic [7:0] OFF_THR  = 8'h1C;
  localparam logic [7:0] OFF_DIV  = 8'h20;

  localparam int CMD_RX_RST  = 2;
  localparam int CMD_TX_RST  = 3;
  localparam int CMD_RX_ON   = 4;
  localparam int CMD_RX_OFF  = 5;
  localparam int CMD_TX_ON   = 6;
  localparam int CMD_TX_OFF  = 7;
  localparam int CMD_ERR_CLR = 8;

  localparam int ST_RXRDY   = 0;
  localparam int ST_TXRDY   = 1;
  localparam int ST_OVRE    = 5;
  localparam int ST_FRAME   = 6;
  localparam int ST_PARE    = 7;
  localparam int ST_TXEMPTY = 9;

  typedef enum logic [1:0] {
    CH_NORMAL = 2'd0,
    CH_ECHO   = 2'd1,
    CH_LOCAL  = 2'd2,
    CH_REMOTE = 2'd3
  } chmode_e;

  typedef enum logic [2:0] {
    SER_IDLE,
    SER_START,
    SER_DATA,
    SER_PAR,
    SER_STOP
  } ser_state_e;

  function automatic logic par_used(input logic [2:0] mode);
    return !mode[2];
  endfunction

  function automatic logic par_value(input logic [2:0] mode, input logic [7:0] d);
    case (mode)
      3'd0:    return ^d;
      3'd1:    return ~^d;
      3'd3:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dbg_uart_baud.sv
module dbg_uart_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || div == '0) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div - 1'b1) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/dbg_uart_tx.sv
module dbg_uart_tx
  import dbg_uart_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       soft_rst,
  input  logic       en,
  input  logic       tick,
  input  logic [2:0] par_mode,
  input  logic       wr,
  input  logic [7:0] wr_data,
  output logic       line,
  output logic       rdy,
  output logic       empty
);
  localparam int SUB_W = $clog2(OVS);
  localparam logic [SUB_W-1:0] LAST = SUB_W'(OVS - 1);

  ser_state_e       st;
  logic [SUB_W-1:0] sub;
  logic [2:0]       bitn;
  logic [7:0]       sh;
  logic             pbit;
  logic [7:0]       hold;
  logic             hold_full;

  assign rdy   = en && !hold_full;
  assign empty = rdy && (st == SER_IDLE);

  always_comb begin
    case (st)
      SER_START: line = 1'b0;
      SER_DATA:  line = sh[0];
      SER_PAR:   line = pbit;
      default:   line = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      st        <= SER_IDLE;
      sub       <= '0;
      bitn      <= '0;
      sh        <= '0;
      pbit      <= 1'b0;
      hold      <= '0;
      hold_full <= 1'b0;
    end else begin
      if (wr && rdy) begin
        hold      <= wr_data;
        hold_full <= 1'b1;
      end
      if (st == SER_IDLE) begin
        if (en && hold_full) begin
          sh        <= hold;
          pbit      <= par_value(par_mode, hold);
          hold_full <= 1'b0;
          st        <= SER_START;
          sub       <= '0;
          bitn      <= '0;
        end
      end else if (tick) begin
        if (sub == LAST) begin
          sub <= '0;
          case (st)
            SER_START: st <= SER_DATA;
            SER_DATA: begin
              sh <= sh >> 1;
              if (bitn == 3'd7) st <= par_used(par_mode) ? SER_PAR : SER_STOP;
              else              bitn <= bitn + 1'b1;
            end
            SER_PAR:  st <= SER_STOP;
            default:  st <= SER_IDLE;
          endcase
        end else begin
          sub <= sub + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dbg_uart_rx.sv
module dbg_uart_rx
  import dbg_uart_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       soft_rst,
  input  logic       en,
  input  logic       tick,
  input  logic [2:0] par_mode,
  input  logic       line,
  output logic       done,
  output logic [7:0] data,
  output logic       ferr,
  output logic       perr
);
  localparam int SUB_W = $clog2(OVS);
  localparam logic [SUB_W-1:0] MID  = SUB_W'(OVS / 2 - 1);
  localparam logic [SUB_W-1:0] LAST = SUB_W'(OVS - 1);

  ser_state_e       st;
  logic [SUB_W-1:0] sub;
  logic [2:0]       bitn;
  logic [7:0]       sh;
  logic             pbit;

  always_ff @(posedge clk) begin
    if (rst || soft_rst || !en) begin
      st   <= SER_IDLE;
      sub  <= '0;
      bitn <= '0;
      sh   <= '0;
      pbit <= 1'b0;
      done <= 1'b0;
      ferr <= 1'b0;
      perr <= 1'b0;
      if (rst) data <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (st)
          SER_IDLE: begin
            if (!line) begin
              st  <= SER_START;
              sub <= '0;
            end
          end
          SER_START: begin
            if (sub == MID) begin
              sub  <= '0;
              bitn <= '0;
              st   <= line ? SER_IDLE : SER_DATA;
            end else begin
              sub <= sub + 1'b1;
            end
          end
          default: begin
            if (sub == LAST) begin
              sub <= '0;
              case (st)
                SER_DATA: begin
                  sh <= {line, sh[7:1]};
                  if (bitn == 3'd7) st <= par_used(par_mode) ? SER_PAR : SER_STOP;
                  else              bitn <= bitn + 1'b1;
                end
                SER_PAR: begin
                  pbit <= line;
                  st   <= SER_STOP;
                end
                default: begin
                  done <= 1'b1;
                  data <= sh;
                  ferr <= !line;
                  perr <= par_used(par_mode) && (pbit != par_value(par_mode, sh));
                  st   <= SER_IDLE;
                end
              endcase
            end else begin
              sub <= sub + 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/dbg_uart.sv
module dbg_uart
  import dbg_uart_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 8,
  parameter int DIV_W  = 16,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              rxd_i,
  output logic              txd_o,
  output logic              irq_o
);
  localparam logic [BUS_W-1:0] IRQ_BITS = BUS_W'((1 << ST_RXRDY) | (1 << ST_TXRDY) |
                                                 (1 << ST_OVRE) | (1 << ST_FRAME) |
                                                 (1 << ST_PARE) | (1 << ST_TXEMPTY));

  logic             wr_acc, rd_acc, cmd_wr, rx_srst, tx_srst, rhr_rd, thr_wr;
  logic             rx_en_q, tx_en_q;
  chmode_e          chmode_q;
  logic [2:0]       par_q;
  logic [DIV_W-1:0] div_q;
  logic [BUS_W-1:0] mask_q, stat, rd_mux;
  logic [7:0]       rhr_q;
  logic             rxrdy_q, ovre_q, frame_q, pare_q;
  logic             rxd_s1, rxd_s2, txd_q, irq_q;
  logic [BUS_W-1:0] rdata_q;
  logic             tick, tx_line, tx_rdy, tx_empty, rx_line;
  logic             rx_done, rx_ferr, rx_perr;
  logic [7:0]       rx_data;

  assign wr_acc  = bus_sel && bus_we;
  assign rd_acc  = bus_sel && !bus_we;
  assign cmd_wr  = wr_acc && bus_addr == ADDR_W'(OFF_CMD);
  assign rx_srst = cmd_wr && bus_wdata[CMD_RX_RST];
  assign tx_srst = cmd_wr && bus_wdata[CMD_TX_RST];
  assign rhr_rd  = rd_acc && bus_addr == ADDR_W'(OFF_RHR);
  assign thr_wr  = wr_acc && bus_addr == ADDR_W'(OFF_THR);

  dbg_uart_baud #(.DIV_W(DIV_W)) u_baud (
    .clk  (clk),
    .rst  (rst),
    .div  (div_q),
    .tick (tick)
  );

  dbg_uart_tx #(.OVS(OVS)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (tx_srst),
    .en       (tx_en_q),
    .tick     (tick),
    .par_mode (par_q),
    .wr       (thr_wr),
    .wr_data  (bus_wdata[7:0]),
    .line     (tx_line),
    .rdy      (tx_rdy),
    .empty    (tx_empty)
  );

  dbg_uart_rx #(.OVS(OVS)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (rx_srst),
    .en       (rx_en_q),
    .tick     (tick),
    .par_mode (par_q),
    .line     (rx_line),
    .done     (rx_done),
    .data     (rx_data),
    .ferr     (rx_ferr),
    .perr     (rx_perr)
  );

  // Channel routing
  always_comb begin
    case (chmode_q)
      CH_LOCAL:  rx_line = tx_line;
      CH_REMOTE: rx_line = 1'b1;
      default:   rx_line = rxd_s2;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxd_s1 <= 1'b1;
      rxd_s2 <= 1'b1;
      txd_q  <= 1'b1;
    end else begin
      rxd_s1 <= rxd_i;
      rxd_s2 <= rxd_s1;
      case (chmode_q)
        CH_NORMAL: txd_q <= tx_line;
        CH_LOCAL:  txd_q <= 1'b1;
        default:   txd_q <= rxd_s2;
      endcase
    end
  end

  // Configuration and enables
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en_q  <= 1'b0;
      tx_en_q  <= 1'b0;
      chmode_q <= CH_NORMAL;
      par_q    <= 3'd0;
      div_q    <= '0;
      mask_q   <= '0;
    end else begin
      if (cmd_wr) begin
        if (bus_wdata[CMD_RX_OFF])     rx_en_q <= 1'b0;
        else if (bus_wdata[CMD_RX_ON]) rx_en_q <= 1'b1;
        if (bus_wdata[CMD_TX_OFF])     tx_en_q <= 1'b0;
        else if (bus_wdata[CMD_TX_ON]) tx_en_q <= 1'b1;
      end
      if (wr_acc && bus_addr == ADDR_W'(OFF_MODE)) begin
        chmode_q <= chmode_e'(bus_wdata[15:14]);
        par_q    <= bus_wdata[11:9];
      end
      if (wr_acc && bus_addr == ADDR_W'(OFF_DIV))  div_q  <= bus_wdata[DIV_W-1:0];
      if (wr_acc && bus_addr == ADDR_W'(OFF_MSET)) mask_q <= mask_q | (bus_wdata & IRQ_BITS);
      if (wr_acc && bus_addr == ADDR_W'(OFF_MCLR)) mask_q <= mask_q & ~bus_wdata;
    end
  end

  // Receive holding register and latched status
  always_ff @(posedge clk) begin
    if (rst) begin
      rhr_q   <= '0;
      rxrdy_q <= 1'b0;
      ovre_q  <= 1'b0;
      frame_q <= 1'b0;
      pare_q  <= 1'b0;
    end else begin
      if (cmd_wr && bus_wdata[CMD_ERR_CLR]) begin
        ovre_q  <= 1'b0;
        frame_q <= 1'b0;
        pare_q  <= 1'b0;
      end
      if (rx_srst) begin
        rxrdy_q <= 1'b0;
      end else if (rx_done) begin
        rhr_q   <= rx_data;
        rxrdy_q <= 1'b1;
        if (rxrdy_q && !rhr_rd) ovre_q <= 1'b1;
        if (rx_ferr) frame_q <= 1'b1;
        if (rx_perr) pare_q  <= 1'b1;
      end else if (rhr_rd) begin
        rxrdy_q <= 1'b0;
      end
    end
  end

  always_comb begin
    stat             = '0;
    stat[ST_RXRDY]   = rxrdy_q;
    stat[ST_TXRDY]   = tx_rdy;
    stat[ST_OVRE]    = ovre_q;
    stat[ST_FRAME]   = frame_q;
    stat[ST_PARE]    = pare_q;
    stat[ST_TXEMPTY] = tx_empty;
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(OFF_MODE): begin
        rd_mux[15:14] = chmode_q;
        rd_mux[11:9]  = par_q;
      end
      ADDR_W'(OFF_MASK): rd_mux = mask_q;
      ADDR_W'(OFF_STAT): rd_mux = stat;
      ADDR_W'(OFF_RHR):  rd_mux[7:0] = rhr_q;
      ADDR_W'(OFF_DIV):  rd_mux[DIV_W-1:0] = div_q;
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (rd_acc) rdata_q <= rd_mux;
      irq_q <= |(stat & mask_q);
    end
  end

  assign bus_rdata = rdata_q;
  assign txd_o     = txd_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/dbg_uart_chk.sv
module dbg_uart_chk #(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic              rxd_s,
  input logic              txd_o,
  input logic              irq_o,
  input logic [1:0]        chmode,
  input logic [BUS_W-1:0]  mask,
  input logic [BUS_W-1:0]  stat,
  input logic              rx_en,
  input logic              rx_done
);
  logic cmd_wr, rhr_rd;
  assign cmd_wr = bus_sel && bus_we && bus_addr == ADDR_W'(8'h00);
  assign rhr_rd = bus_sel && !bus_we && bus_addr == ADDR_W'(8'h18);

  a_r2_rx_off_wins: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && bus_wdata[5]) |=> !rx_en);

  a_r2_tx_off_wins: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && bus_wdata[7]) |=> !stat[1]);

  a_r5_read_clears_rxrdy: assert property (@(posedge clk) disable iff (rst)
    (rhr_rd && !rx_done) |=> !stat[0]);

  a_r7_ovre_sticky: assert property (@(posedge clk) disable iff (rst)
    (stat[5] && !(cmd_wr && bus_wdata[8])) |=> stat[5]);

  a_r7_frame_sticky: assert property (@(posedge clk) disable iff (rst)
    (stat[6] && !(cmd_wr && bus_wdata[8])) |=> stat[6]);

  a_r9_no_mask_no_irq: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> !irq_o);

  a_r10_echo_copy: assert property (@(posedge clk) disable iff (rst)
    (chmode == 2'd1) |=> (txd_o == $past(rxd_s)));

  a_r11_local_pin_high: assert property (@(posedge clk) disable iff (rst)
    (chmode == 2'd2) |=> txd_o);

  a_r12_remote_copy: assert property (@(posedge clk) disable iff (rst)
    (chmode == 2'd3) |=> (txd_o == $past(rxd_s)));
endmodule

bind dbg_uart dbg_uart_chk #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .rxd_s     (rxd_s2),
  .txd_o     (txd_o),
  .irq_o     (irq_o),
  .chmode    (chmode_q),
  .mask      (mask_q),
  .stat      (stat),
  .rx_en     (rx_en_q),
  .rx_done   (rx_done)
);

// File: tb/dbg_uart_bench.sv
module dbg_uart_bench;
  localparam int DIVV = 2;
  localparam int BIT  = 16 * DIVV;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rxd = 1'b1;
  logic        txd, irq;

  int checks = 0;
  int errors = 0;

  dbg_uart u_dbg_uart (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxd_i(rxd), .txd_o(txd), .irq_o(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0; d = bus_rdata;
  endtask

  function automatic logic exp_par(input int pm, input logic [7:0] d);
    case (pm)
      0: return ^d;
      1: return ~^d;
      3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic drive_bit(input logic b);
    rxd = b;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int pm, input bit bad_par, input bit bad_stop);
    @(negedge clk);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (pm < 4) drive_bit(exp_par(pm, d) ^ bad_par);
    drive_bit(!bad_stop);
    rxd = 1'b1;
  endtask

  // Checks the pin against the frame driven on rxd, at mid-bit
  task automatic watch_copy(input logic [7:0] d, input string req);
    logic [9:0] bits;
    bits = {1'b1, d, 1'b0};
    @(negedge clk);
    repeat (BIT / 2) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      chk(req, {31'b0, txd}, {31'b0, bits[i]});
      repeat (BIT) @(negedge clk);
    end
  endtask

  task automatic catch_tx(input int pm, output logic [7:0] d, output logic p, output logic s, output bit ok);
    int n;
    n = 0;
    ok = 1;
    while (txd !== 1'b0 && n < 20 * BIT) begin @(negedge clk); n++; end
    if (n >= 20 * BIT) begin ok = 0; d = '0; p = 0; s = 0; return; end
    repeat (BIT / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin repeat (BIT) @(negedge clk); d[i] = txd; end
    p = 1'b0;
    if (pm < 4) begin repeat (BIT) @(negedge clk); p = txd; end
    repeat (BIT) @(negedge clk); s = txd;
  endtask

  task automatic wait_rxrdy(output logic [31:0] st);
    int n;
    n = 0;
    rd(8'h14, st);
    while (!st[0] && n < 1000) begin rd(8'h14, st); n++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r, st;
    logic [7:0]  d, d2;
    logic        p, s;
    bit          ok;
    int          pm, lowc;

    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state and readback
    rd(8'h14, r); chk("R1 status after reset", r, 32'h0);
    rd(8'h10, r); chk("R1 mask after reset", r, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    chk("R1 txd idle", {31'b0, txd}, 32'h1);
    wr(8'h20, DIVV);
    rd(8'h20, r); chk("R1 divisor readback", r, DIVV);
    wr(8'h04, 32'h800);
    rd(8'h04, r); chk("R1 mode readback", r, 32'h800);

    // R2 enable and disable together: disable wins
    wr(8'h00, 32'hF0);
    rd(8'h14, r); chk("R2 tx off wins, TXRDY", r & 32'h2, 32'h0);
    send_frame(8'h5A, 4, 0, 0);
    rd(8'h14, r); chk("R2 rx off, nothing received", r & 32'h1, 32'h0);

    // R8 enable both
    wr(8'h00, 32'h50);
    rd(8'h14, r); chk("R8 TXRDY and TXEMPTY when idle", r, 32'h202);

    // R5 receive and read clears
    send_frame(8'hA5, 4, 0, 0);
    rd(8'h14, r); chk("R5 RXRDY after frame", r, 32'h203);
    rd(8'h18, r); chk("R5 received byte", r, 32'hA5);
    rd(8'h14, r); chk("R5 RXRDY cleared by read", r & 32'h1, 32'h0);

    // R5 short glitch is no start bit
    @(negedge clk); rxd = 0; repeat (4) @(negedge clk); rxd = 1;
    repeat (12 * BIT) @(negedge clk);
    rd(8'h14, r); chk("R5 glitch ignored", r & 32'h1, 32'h0);

    // R6 overrun
    send_frame(8'h11, 4, 0, 0);
    send_frame(8'h22, 4, 0, 0);
    rd(8'h14, r); chk("R6 OVRE and RXRDY", r & 32'h21, 32'h21);
    rd(8'h18, r); chk("R6 newest byte kept", r, 32'h22);
    rd(8'h14, r); chk("R7 OVRE sticky after read", r & 32'h20, 32'h20);
    wr(8'h00, 32'h100);
    rd(8'h14, r); chk("R7 OVRE cleared by command", r & 32'h20, 32'h0);

    // R4 receiver parity styles, R7 parity error
    for (int m = 0; m < 4; m++) begin
      d = 8'($urandom);
      wr(8'h04, m << 9);
      send_frame(d, m, 0, 0);
      rd(8'h18, r); chk("R4 byte with parity", r, {24'b0, d});
      rd(8'h14, r); chk("R4 good parity, no PARE", r & 32'h80, 32'h0);
      send_frame(d, m, 1, 0);
      rd(8'h18, r);
      rd(8'h14, r); chk("R7 PARE on bad parity", r & 32'h80, 32'h80);
      wr(8'h00, 32'h100);
    end

    // R7 framing error, sticky; R13 receiver reset clears RXRDY
    wr(8'h04, 32'h800);
    send_frame(8'h3C, 4, 0, 1);
    rd(8'h18, r);
    rd(8'h14, r); chk("R7 FRAME on low stop, sticky over read", r & 32'h40, 32'h40);
    repeat (12 * BIT) @(negedge clk);
    wr(8'h00, 32'h114);
    rd(8'h14, r); chk("R13 rx reset clears RXRDY, R7 clear", r & 32'hE1, 32'h0);

    // R3 R4 transmit format, R8 ignored write while holding register full
    for (int m = 0; m < 5; m++) begin
      d = 8'($urandom) | 8'h01;
      wr(8'h04, m << 9);
      wr(8'h1C, {24'b0, d});
      catch_tx(m, d2, p, s, ok);
      chk("R3 tx frame found", {31'b0, ok}, 32'h1);
      chk("R3 tx data bits", {24'b0, d2}, {24'b0, d});
      if (m < 4) chk("R4 tx parity bit", {31'b0, p}, {31'b0, exp_par(m, d)});
      chk("R3 tx stop bit", {31'b0, s}, 32'h1);
      repeat (BIT) @(negedge clk);
    end
    wr(8'h04, 32'h800);
    wr(8'h1C, 32'h81);
    lowc = 0;
    while (txd !== 1'b0) @(negedge clk);
    while (txd === 1'b0) begin lowc++; @(negedge clk); end
    chk("R3 start bit length 16*div", lowc, BIT);
    repeat (12 * BIT) @(negedge clk);
    wr(8'h1C, 32'h01);
    wr(8'h1C, 32'h02);
    wr(8'h1C, 32'h03);
    catch_tx(4, d2, p, s, ok); chk("R8 first byte", {24'b0, d2}, 32'h01);
    catch_tx(4, d2, p, s, ok); chk("R8 second byte", {24'b0, d2}, 32'h02);
    catch_tx(4, d2, p, s, ok); chk("R8 third write ignored", {31'b0, ok}, 32'h0);
    rd(8'h14, r); chk("R8 TXEMPTY after drain", r & 32'h202, 32'h202);

    // R11 local loopback with random data and parity
    for (int k = 0; k < 16; k++) begin
      pm = $urandom_range(4, 0);
      d  = 8'($urandom);
      wr(8'h04, (2 << 14) | (pm << 9));
      wr(8'h1C, {24'b0, d});
      repeat (BIT) @(negedge clk);
      chk("R11 pin high in local loopback", {31'b0, txd}, 32'h1);
      wait_rxrdy(st);
      chk("R11 loopback status", st & 32'hE1, 32'h01);
      rd(8'h18, r); chk("R11 loopback byte", r, {24'b0, d});
    end

    // R9 interrupt mask
    wr(8'h08, 32'h1);
    rd(8'h10, r); chk("R9 mask set", r, 32'h1);
    wr(8'h1C, 32'h6E);
    wait_rxrdy(st);
    chk("R9 irq on RXRDY", {31'b0, irq}, 32'h1);
    wr(8'h0C, 32'h1);
    @(negedge clk);
    chk("R9 irq drops after mask clear", {31'b0, irq}, 32'h0);
    rd(8'h18, r);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h10, r); chk("R9 only status bits maskable", r, 32'h2E3);
    chk("R9 irq from TXRDY", {31'b0, irq}, 32'h1);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h10, r); chk("R9 mask cleared", r, 32'h0);

    // R10 echo
    wr(8'h04, (1 << 14) | 32'h800);
    fork
      send_frame(8'hB4, 4, 0, 0);
      watch_copy(8'hB4, "R10 echo pin copy");
    join
    rd(8'h18, r); chk("R10 echo still received", r, 32'hB4);

    // R12 remote loopback
    wr(8'h04, (3 << 14) | 32'h800);
    fork
      send_frame(8'hC3, 4, 0, 0);
      watch_copy(8'hC3, "R12 remote pin copy");
    join
    rd(8'h14, r); chk("R12 receiver isolated", r & 32'h1, 32'h0);

    // R13 transmitter reset mid-character
    wr(8'h04, 32'h800);
    wr(8'h1C, 32'h00);
    repeat (3 * BIT) @(negedge clk);
    chk("R13 tx busy before reset", {31'b0, txd}, 32'h0);
    wr(8'h00, 32'h8);
    repeat (3) @(negedge clk);
    chk("R13 pin high after tx reset", {31'b0, txd}, 32'h1);
    rd(8'h14, r); chk("R13 TXEMPTY after tx reset", r & 32'h202, 32'h202);

    // R13 receiver reset drops character in progress
    fork
      send_frame(8'hFF, 4, 0, 0);
      begin repeat (3 * BIT) @(negedge clk); wr(8'h00, 32'h14); end
    join
    repeat (2 * BIT) @(negedge clk);
    rd(8'h14, r); chk("R13 dropped character", r & 32'h1, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule